// File: doc/BRIEF.md
# DDC1 EDID Serial Transmitter with DDC2 Switch Detection

This block sends display identification bytes to a graphics host over the one-wire DDC1 scheme. The host paces transfers by toggling the vertical sync line. On each rising edge of that line, once it has been synchronized, the block drives the next bit onto its serial data output. A byte goes out as eight data bits, most significant first, followed by a ninth bit held high. Each byte comes from one of two sources. In automatic mode it is read from an external EDID buffer at an internal pointer, and the pointer then advances and wraps inside a 128-byte or 256-byte window. In software mode it comes from a hold register, and an interrupt flag asks the CPU to refill that register during the ninth bit.

A falling edge on the DDC2 clock pin means the host has moved to the two-wire protocol. The block then latches DDC2 mode permanently, raises a mode-switch flag, stops shifting and releases the data line high. A small single-cycle register bus gives access to the control/status register, the pointer and the hold register. The serial output is paced only by the host, so it has no valid/ready handshake and no back-pressure. The buffer read port is combinational: `buf_data` must be valid in the same cycle as `buf_addr`.

Top module: `ddc1_edid_tx`

## Requirements
- R1: After reset the control register (bus address 0) reads 0x00, the pointer (address 1) and the hold register (address 2) read 0x00, address 3 reads 0x00, `sda_out` is 1 and both interrupt outputs are 0.
- R2: While enabled and in DDC1 mode, each synchronized rising edge of `vsync_in` advances one bit. The first eight edges of a byte drive its bits MSB first, and the ninth drives 1. `sda_out` changes on the third clock edge after `vsync_in` rises.
- R3: In automatic mode (control bit1 = 0) the byte is fetched from the buffer at the pointer on its first bit edge, and the pointer then increments. With control bit2 = 0 the increment is masked to 7 bits (127 wraps to 0). With bit2 = 1 it is 8 bits (255 wraps to 0).
- R4: In software mode (control bit1 = 1) the byte is taken from the hold register and the pointer does not move. The ninth bit edge sets the DDC1 flag (control bit3), which drives `ddc1_irq`.
- R5: Writing 0 to a flag bit (control bit3 or bit4) clears it. Writing 1 leaves it unchanged, so a write cannot set a flag.
- R6: With the enable bit (control bit0) at 0, `vsync_in` is ignored: the output, the bit position and the pointer hold.
- R7: A synchronized falling edge of `scl_in` while in DDC1 mode sets the DDC2 bit (control bit5, read-only) and the switch flag (control bit4, drives `mode_irq`). DDC2 persists until reset. From the next cycle on, `sda_out` is 1 and no bits are shifted.
- R8: Control bits 7:6 always read 0. Bits 0 (enable), 1 (software mode) and 2 (256-byte window) read back as written.
- R9: A bus write to the hold register in the same cycle as an automatic fetch is ignored, and the register holds the fetched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Asynchronous vertical sync from the host, which serves as the DDC1 bit clock |
| scl_in | input | 1 | Asynchronous DDC2 clock pin |
| reg_addr | input | 2 | Register select: 0 control, 1 pointer, 2 hold |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| buf_addr | output | 8 | EDID buffer read address (the pointer) |
| buf_data | input | 8 | EDID buffer read data for `buf_addr` |
| sda_out | output | 1 | Serial data out, high when idle |
| ddc1_irq | output | 1 | DDC1 software-service interrupt request |
| mode_irq | output | 1 | DDC1-to-DDC2 switch interrupt request |

## Verification
The bench walks pointer start values across both window sizes, including 127 and 255 and an out-of-window start in 128-byte mode. A design with the wrong wrap mask would leave the pointer at 128 or let it escape the window. It pauses the transmitter in the middle of a run and resumes it, to show that a disabled design neither advances the pointer nor loses its place in the bit count. In software mode it checks that the flag rises only on the ninth edge, that it survives a write of 1, and that the pointer stays put. It forces a hold-register write into the fetch cycle, and it drops the DDC2 clock in the middle of a byte whose current bit is 0. A design that let the DDC2 latch be cleared, or kept shifting after the switch, shows up at `sda_out` and in the control register.

// File: rtl/ddc1_pkg.sv
package ddc1_pkg;
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_PTR  = 2'd1;
  localparam logic [1:0] RA_HOLD = 2'd2;

  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_SW     = 1;
  localparam int unsigned CB_WIDE   = 2;
  localparam int unsigned CB_D1FLAG = 3;
  localparam int unsigned CB_SWFLAG = 4;
  localparam int unsigned CB_DDC2   = 5;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
endpackage

// File: rtl/ddc_sync_edge.sv
module ddc_sync_edge #(
  parameter int unsigned STAGES = 2,
  parameter logic RESET_VAL = 1'b0,
  parameter ddc1_pkg::edge_kind_e KIND = ddc1_pkg::EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic prev_q;
  logic level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RESET_VAL}};
      prev_q <= RESET_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];

  generate
    if (KIND == ddc1_pkg::EDGE_RISE) begin : g_rise
      assign edge_o = level & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~level & prev_q;
    end
  endgenerate

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/ddc1_shifter.sv
module ddc1_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              idle_i,
  input  logic [DATA_W-1:0] load_i,
  output logic              byte_start_o,
  output logic              frame_end_o,
  output logic              sda_o
);
  localparam int unsigned IW = $clog2(DATA_W + 1);
  localparam logic [IW-1:0] LAST = IW'(DATA_W);

  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              sda_q;

  assign byte_start_o = step_i && (idx_q == '0);
  assign frame_end_o  = step_i && (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sh_q  <= '0;
      sda_q <= 1'b1;
    end else if (idle_i) begin
      sda_q <= 1'b1;
    end else if (step_i) begin
      if (idx_q == '0) begin
        sda_q <= load_i[DATA_W-1];
        sh_q  <= {load_i[DATA_W-2:0], 1'b0};
        idx_q <= idx_q + 1'b1;
      end else if (idx_q == LAST) begin
        sda_q <= 1'b1;
        idx_q <= '0;
      end else begin
        sda_q <= sh_q[DATA_W-1];
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign sda_o = sda_q;

  // R2
  ninth_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> sda_o);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !idle_i) |=> $stable(sda_o));
endmodule

// File: rtl/ddc1_edid_tx.sv
module ddc1_edid_tx #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic              scl_in,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [DATA_W-1:0] buf_data,
  output logic              sda_out,
  output logic              ddc1_irq,
  output logic              mode_irq
);
  import ddc1_pkg::*;

  localparam logic [ADDR_W-1:0] NARROW_MASK = {1'b0, {(ADDR_W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] WIDE_MASK   = {ADDR_W{1'b1}};

  logic en_q, sw_q, wide_q, d1flag_q, swflag_q, ddc2_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] hold_q;
  logic vs_rise, scl_fall, step, byte_start, frame_end;
  logic ctrl_wr, ptr_wr, hold_wr, auto_fetch;
  logic [ADDR_W-1:0] ptr_next;
  logic [DATA_W-1:0] load_byte;

  ddc_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .KIND(EDGE_RISE)) u_vs (
    .clk(clk), .rst_n(rst_n), .async_i(vsync_in), .edge_o(vs_rise));

  ddc_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1), .KIND(EDGE_FALL)) u_scl (
    .clk(clk), .rst_n(rst_n), .async_i(scl_in), .edge_o(scl_fall));

  assign step       = vs_rise && en_q && !ddc2_q;
  assign ctrl_wr    = reg_we && (reg_addr == RA_CTRL);
  assign ptr_wr     = reg_we && (reg_addr == RA_PTR);
  assign hold_wr    = reg_we && (reg_addr == RA_HOLD);
  assign auto_fetch = byte_start && !sw_q;
  assign load_byte  = sw_q ? hold_q : buf_data;
  assign ptr_next   = (ptr_q + 1'b1) & (wide_q ? WIDE_MASK : NARROW_MASK);

  ddc1_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .step_i(step), .idle_i(ddc2_q),
    .load_i(load_byte), .byte_start_o(byte_start),
    .frame_end_o(frame_end), .sda_o(sda_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sw_q     <= 1'b0;
      wide_q   <= 1'b0;
      d1flag_q <= 1'b0;
      swflag_q <= 1'b0;
      ddc2_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= reg_wdata[CB_EN];
        sw_q   <= reg_wdata[CB_SW];
        wide_q <= reg_wdata[CB_WIDE];
      end
      if (frame_end && sw_q) d1flag_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata[CB_D1FLAG]) d1flag_q <= 1'b0;
      if (scl_fall && !ddc2_q) begin
        swflag_q <= 1'b1;
        ddc2_q   <= 1'b1;
      end else if (ctrl_wr && !reg_wdata[CB_SWFLAG]) begin
        swflag_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      hold_q <= '0;
    end else begin
      if (auto_fetch) ptr_q <= ptr_next;
      else if (ptr_wr) ptr_q <= reg_wdata[ADDR_W-1:0];
      if (auto_fetch) hold_q <= buf_data;
      else if (hold_wr) hold_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_EN]     = en_q;
        reg_rdata[CB_SW]     = sw_q;
        reg_rdata[CB_WIDE]   = wide_q;
        reg_rdata[CB_D1FLAG] = d1flag_q;
        reg_rdata[CB_SWFLAG] = swflag_q;
        reg_rdata[CB_DDC2]   = ddc2_q;
      end
      RA_PTR:  reg_rdata[ADDR_W-1:0] = ptr_q;
      RA_HOLD: reg_rdata = hold_q;
      default: reg_rdata = '0;
    endcase
  end

  assign buf_addr = ptr_q;
  assign ddc1_irq = d1flag_q;
  assign mode_irq = swflag_q;

  // R7
  ddc2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddc2_q |=> ddc2_q);

  // R7
  ddc2_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddc2_q |=> sda_out);

  // R4
  d1flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d1flag_q) |-> $past(sw_q && en_q && !ddc2_q));

  // R3
  narrow_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_fetch && !wide_q) |-> !ptr_q[ADDR_W-1]);

  // R6
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ptr_wr) |=> $stable(ptr_q));
endmodule

// File: tb/ddc1_edid_tx_test.sv
module ddc1_edid_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_in = 1'b0;
  logic scl_in = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] buf_addr;
  logic [7:0] buf_data;
  logic sda_out, ddc1_irq, mode_irq;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign buf_data = buf_addr ^ 8'hA5;

  ddc1_edid_tx uut (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .scl_in(scl_in),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .buf_addr(buf_addr), .buf_data(buf_data),
    .sda_out(sda_out), .ddc1_irq(ddc1_irq), .mode_irq(mode_irq));

  // {start pointer, wide window, expected pointer after one byte}
  localparam logic [16:0] VEC [5] = '{
    {8'h10, 1'b0, 8'h11},
    {8'h7F, 1'b0, 8'h00},
    {8'hFF, 1'b1, 8'h00},
    {8'h7F, 1'b1, 8'h80},
    {8'hC3, 1'b0, 8'h44}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic vedge();
    @(negedge clk);
    vsync_in = 1'b1;
    repeat (4) @(negedge clk);
    vsync_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input string tag, input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      vedge();
      chk(tag, {7'd0, sda_out}, {7'd0, b[7-i]});
    end
    vedge();
    chk({tag, " ninth"}, {7'd0, sda_out}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 00 expected 01");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 ptr", v, 8'h00);
    rd(2'd2, v); chk("R1 hold", v, 8'h00);
    rd(2'd3, v); chk("R1 addr3", v, 8'h00);
    chk("R1 outs", {5'd0, sda_out, ddc1_irq, mode_irq}, 8'h04);

    // R2/R3 vector table: automatic mode, both windows
    for (int k = 0; k < 5; k++) begin
      logic [7:0] st, nx;
      logic wide;
      {st, wide, nx} = VEC[k];
      wr(2'd0, {5'd0, wide, 2'b01});
      rd(2'd0, v); chk("R8 ctrl readback", v, {5'd0, wide, 2'b01});
      wr(2'd1, st);
      send_byte("R2 auto byte", st ^ 8'hA5);
      rd(2'd1, v); chk("R3 pointer wrap", v, nx);
      rd(2'd2, v); chk("R3 hold fetched", v, st ^ 8'hA5);
    end

    // R4 software mode
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h3C);
    for (int i = 0; i < 8; i++) begin
      vedge();
      chk("R4 sw bit", {7'd0, sda_out}, {7'd0, 8'h3C >> (7 - i)} & 8'h01);
    end
    chk("R4 no flag before ninth", {7'd0, ddc1_irq}, 8'd0);
    vedge();
    chk("R4 flag on ninth", {7'd0, ddc1_irq}, 8'd1);
    rd(2'd1, v); chk("R4 pointer held", v, 8'h44);
    // R5 flag write semantics
    wr(2'd0, 8'h0B);
    chk("R5 write one keeps", {7'd0, ddc1_irq}, 8'd1);
    wr(2'd0, 8'h03);
    chk("R5 write zero clears", {7'd0, ddc1_irq}, 8'd0);
    wr(2'd0, 8'h1B);
    rd(2'd0, v); chk("R5 write one cannot set", v, 8'h03);
    wr(2'd2, 8'hA6);
    send_byte("R4 second sw byte", 8'hA6);

    // R6 disable mid-run
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h90);
    vedge();
    chk("R6 first bit", {7'd0, sda_out}, 8'd0);
    wr(2'd0, 8'h04);
    vedge(); vedge(); vedge();
    chk("R6 sda held", {7'd0, sda_out}, 8'd0);
    rd(2'd1, v); chk("R6 ptr held", v, 8'h91);
    wr(2'd0, 8'h05);
    for (int i = 1; i < 8; i++) begin
      vedge();
      chk("R6 resume bit", {7'd0, sda_out}, {7'd0, 8'h35 >> (7 - i)} & 8'h01);
    end
    vedge();
    chk("R6 resume ninth", {7'd0, sda_out}, 8'd1);

    // R9 hold write collides with automatic fetch
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h20);
    @(negedge clk);
    vsync_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 2'd2; reg_wdata = 8'h55; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(2'd2, v); chk("R9 hold write ignored", v, 8'h85);
    chk("R9 first bit", {7'd0, sda_out}, 8'd1);
    repeat (2) @(negedge clk);
    vsync_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 1; i < 8; i++) begin
      vedge();
      chk("R9 bit", {7'd0, sda_out}, {7'd0, 8'h85 >> (7 - i)} & 8'h01);
    end
    vedge();

    // R7 switch to DDC2 mid-byte
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h80);
    vedge();
    chk("R7 pre-switch bit", {7'd0, sda_out}, 8'd0);
    @(negedge clk);
    scl_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 sda released", {7'd0, sda_out}, 8'd1);
    chk("R7 mode irq", {7'd0, mode_irq}, 8'd1);
    rd(2'd0, v); chk("R7 ctrl after switch", v, 8'h35);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R7 ddc2 sticky", v, 8'h25);
    chk("R7 switch flag cleared", {7'd0, mode_irq}, 8'd0);
    vedge(); vedge();
    chk("R7 no shifting", {7'd0, sda_out}, 8'd1);
    rd(2'd1, v); chk("R7 ptr frozen", v, 8'h81);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule